// File: doc/BRIEF.md
# Charge-Redistribution SAR Conversion Controller

This block sequences the switches of a successive-approximation converter built on a binary-weighted capacitor array. A single-cycle start request opens a conversion. First the array samples the input with its common node grounded. Then every switch opens so that the charge is trapped. Next all bottom plates are driven to ground. Last, a binary search runs from the most significant capacitor down to the least significant, one decision per bit, using a single comparator bit.

The comparator reports 1 when the common node sits below zero, which means the input is above the trial level. On a 1 the capacitor under test stays on the reference; on a 0 it goes back to ground. Each switch change is followed by a settling cycle before the comparator is sampled, and the first (largest) step gets extra settling cycles. The dummy capacitor is never switched and is tied to ground outside the block. When the last bit is decided, the code is registered on the result port and a one-cycle done pulse is given.

Top module: `sar_cr_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, com_gnd_o, in_conn_o and plate_drv_o are 0 and plate_ref_o and result_o are all zeros.
- R2: A start_i sampled high while idle gives, from the next cycle, exactly ACQ_CYCLES cycles with com_gnd_o=1, in_conn_o=1, plate_drv_o=0 and plate_ref_o all zeros.
- R3: The acquisition is followed by exactly one cycle in which com_gnd_o, in_conn_o and plate_drv_o are all 0.
- R4: That cycle is followed by exactly one cycle with plate_drv_o=1 and plate_ref_o all zeros (every bottom plate on ground).
- R5: The search opens with only plate_ref_o[WIDTH-1] set, held for 2+MSB_SETTLE cycles. The comparator is sampled at the clock edge that ends the last of these cycles.
- R6: At each decision, a cmp_i of 1 keeps the tested bit at 1 and a cmp_i of 0 clears it. At the same edge the next lower bit is set. Each lower bit is held for 2 cycles, and the higher bits keep their decided values.
- R7: In the cycle after the bit-0 decision, done_o is 1 for that one cycle, plate_drv_o and plate_ref_o return to 0, and result_o shows the decided code. result_o then holds that code until the next done_o.
- R8: busy_o is 1 from the cycle after the accepted start through the bit-0 decision cycle, and is 0 while done_o is 1. start_i while busy_o is 1 has no effect on any output.
- R9: plate_drv_o is never 1 in the same cycle as in_conn_o or com_gnd_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled when idle |
| cmp_i | input | 1 | Comparator: 1 = common node below zero |
| com_gnd_o | output | 1 | Common-terminal ground switch closed |
| in_conn_o | output | 1 | Free terminals connected to the input |
| plate_drv_o | output | 1 | Bottom plates driven to ground/reference per plate_ref_o |
| plate_ref_o | output | WIDTH | Per-capacitor select, 1 = reference, 0 = ground |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| result_o | output | WIDTH | Last converted code |

## Verification
On every cycle, the assertions check break-before-make between sampling and plate drive, the all-open state at the end of acquisition, plates on ground while the input is connected, a one-hot bit pointer, the keep or clear of each decided bit, and a done pulse that lasts one cycle outside busy. Only the bench scenarios can show the exact phase lengths, the settle counts for the first and later steps, the final code for different input codes, and that start requests during a conversion neither restart nor lengthen it. For these, a reference model predicts every output on every cycle.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_HOLD,
    ST_GND,
    ST_SRCH
  } sar_state_e;
endpackage

// File: rtl/sar_phase_seq.sv
`timescale 1ns/1ps
module sar_phase_seq
  import sar_pkg::*;
#(
  parameter int ACQ_CYCLES = 4,
  parameter int MSB_SETTLE = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic last_i,
  output logic com_gnd_o,
  output logic in_conn_o,
  output logic plate_drv_o,
  output logic search_o,
  output logic busy_o,
  output logic load_o,
  output logic decide_o,
  output logic done_o
);
  localparam int CNT_MAX = (ACQ_CYCLES > MSB_SETTLE + 1) ? ACQ_CYCLES : MSB_SETTLE + 1;
  localparam int CW      = $clog2(CNT_MAX + 1);

  sar_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_ACQ;
          cnt_q   <= CW'(ACQ_CYCLES - 1);
        end
        ST_ACQ: begin
          if (cnt_q == '0) state_q <= ST_HOLD;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_HOLD: state_q <= ST_GND;
        ST_GND: begin
          state_q <= ST_SRCH;
          cnt_q   <= CW'(MSB_SETTLE + 1);
        end
        ST_SRCH: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else if (last_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else cnt_q <= CW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign com_gnd_o   = (state_q == ST_ACQ);
  assign in_conn_o   = (state_q == ST_ACQ);
  assign plate_drv_o = (state_q == ST_GND) || (state_q == ST_SRCH);
  assign search_o    = (state_q == ST_SRCH);
  assign busy_o      = (state_q != ST_IDLE);
  assign load_o      = (state_q == ST_GND);
  assign decide_o    = (state_q == ST_SRCH) && (cnt_q == '0);
  assign done_o      = done_q;

  AST_BUSY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(decide_o && last_i)) |=> busy_o); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R8
  AST_HOLD_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_conn_o) |-> (!plate_drv_o && !com_gnd_o)); // R3
  AST_BREAK_MAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plate_drv_o |-> (!in_conn_o && !com_gnd_o)); // R9
endmodule

// File: rtl/sar_bit_reg.sv
`timescale 1ns/1ps
module sar_bit_reg #(
  parameter int WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             decide_i,
  input  logic             cmp_i,
  input  logic             search_i,
  output logic             last_o,
  output logic [WIDTH-1:0] plate_ref_o,
  output logic [WIDTH-1:0] result_o
);
  localparam logic [WIDTH-1:0] MSB_ONE = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] trial_q, mask_q, result_q;
  logic [WIDTH-1:0] trial_dec, mask_nxt;

  always_comb begin
    trial_dec = cmp_i ? trial_q : (trial_q & ~mask_q);
    mask_nxt  = mask_q >> 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trial_q  <= '0;
      mask_q   <= '0;
      result_q <= '0;
    end else if (load_i) begin
      trial_q <= MSB_ONE;
      mask_q  <= MSB_ONE;
    end else if (decide_i) begin
      trial_q <= trial_dec | mask_nxt;
      mask_q  <= mask_nxt;
      if (mask_q[0]) result_q <= trial_dec;
    end
  end

  assign last_o      = mask_q[0];
  assign plate_ref_o = search_i ? trial_q : '0;
  assign result_o    = result_q;

  AST_MASK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mask_q)); // R6
  AST_LOAD_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (trial_q == MSB_ONE)); // R5
  AST_KEEP_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide_i && cmp_i) |=> ((trial_q & $past(mask_q)) != '0)); // R6
  AST_DROP_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide_i && !cmp_i) |=> ((trial_q & $past(mask_q)) == '0)); // R6
endmodule

// File: rtl/sar_cr_ctrl.sv
`timescale 1ns/1ps
module sar_cr_ctrl #(
  parameter int WIDTH      = 12,
  parameter int ACQ_CYCLES = 4,
  parameter int MSB_SETTLE = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             com_gnd_o,
  output logic             in_conn_o,
  output logic             plate_drv_o,
  output logic [WIDTH-1:0] plate_ref_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);
  logic last, search, load, decide;

  sar_phase_seq #(
    .ACQ_CYCLES(ACQ_CYCLES),
    .MSB_SETTLE(MSB_SETTLE)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .last_i     (last),
    .com_gnd_o  (com_gnd_o),
    .in_conn_o  (in_conn_o),
    .plate_drv_o(plate_drv_o),
    .search_o   (search),
    .busy_o     (busy_o),
    .load_o     (load),
    .decide_o   (decide),
    .done_o     (done_o)
  );

  sar_bit_reg #(
    .WIDTH(WIDTH)
  ) i_bits (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .decide_i   (decide),
    .cmp_i      (cmp_i),
    .search_i   (search),
    .last_o     (last),
    .plate_ref_o(plate_ref_o),
    .result_o   (result_o)
  );

  AST_ACQ_PLATES_GND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_conn_o |-> (plate_ref_o == '0 && !plate_drv_o)); // R2
endmodule

// File: tb/test_sar_cr_ctrl.sv
`timescale 1ns/1ps
module test_sar_cr_ctrl;
  localparam int N   = 12;
  localparam int ACQ = 4;
  localparam int EXT = 2;
  localparam int P0  = 2 + EXT;
  localparam int L   = ACQ + 2 + P0 + 2 * (N - 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] code = '0;
  logic cmp;
  logic com_gnd, in_conn, plate_drv, busy, done;
  logic [N-1:0] plate_ref, result;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int t = 0;
  bit mdone = 1'b0;
  logic [N-1:0] mres = '0;

  always #4 clk = ~clk;

  // ideal comparator: input above trial level -> node below zero -> 1
  assign cmp = (code >= plate_ref);

  sar_cr_ctrl #(.WIDTH(N), .ACQ_CYCLES(ACQ), .MSB_SETTLE(EXT)) i_sar_cr_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .cmp_i(cmp),
    .com_gnd_o(com_gnd), .in_conn_o(in_conn), .plate_drv_o(plate_drv),
    .plate_ref_o(plate_ref), .busy_o(busy), .done_o(done), .result_o(result));

  task automatic chk(input string rq, input string nm, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", rq, nm, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_ni) begin
      if (t != 0) begin
        if (t == L) begin t = 0; mdone = 1'b1; mres = code; end
        else t++;
      end else begin
        mdone = 1'b0;
        if (start) t = 1;
      end
    end
  end

  always @(negedge clk) begin
    string rq;
    logic eb, eg, ei, ed;
    logic [N-1:0] ep;
    if (rst_ni) begin
      eb = 1'b0; eg = 1'b0; ei = 1'b0; ed = 1'b0; ep = '0;
      if (t == 0) rq = mdone ? "R7" : "R1";
      else if (t <= ACQ) begin eb = 1'b1; eg = 1'b1; ei = 1'b1; rq = "R2"; end
      else if (t == ACQ + 1) begin eb = 1'b1; rq = "R3"; end
      else if (t == ACQ + 2) begin eb = 1'b1; ed = 1'b1; rq = "R4"; end
      else begin
        int s, b;
        s  = t - (ACQ + 3);
        b  = (s < P0) ? N - 1 : N - 2 - (s - P0) / 2;
        eb = 1'b1; ed = 1'b1;
        ep = ((code >> (b + 1)) << (b + 1)) | (N'(1) << b);
        rq = (s < P0) ? "R5" : "R6";
      end
      chk("R8", "busy", int'(busy), int'(eb));
      chk("R7", "done", int'(done), int'(mdone));
      chk("R7", "result", int'(result), int'(mres));
      chk(rq, "com_gnd", int'(com_gnd), int'(eg));
      chk(rq, "in_conn", int'(in_conn), int'(ei));
      chk(rq, "plate_drv", int'(plate_drv), int'(ed));
      chk(rq, "plate_ref", int'(plate_ref), int'(ep));
      chk("R9", "break_make", int'(plate_drv & (in_conn | com_gnd)), 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // spam != 0: extra start requests while busy (R8 ignore check)
  task automatic conv(input logic [N-1:0] c, input bit spam);
    int k = 0;
    code  = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    do begin
      @(negedge clk);
      k++;
      start = spam && (k == 2 || k == 9 || k == L - 1);
    end while (!mdone);
    start = 1'b0;
    chk("R7", "final_code", int'(result), int'(c));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "busy_in_reset", int'(busy), 0);
    chk("R1", "result_in_reset", int'(result), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    @(negedge clk);
    conv(12'd2048, 1'b0);
    conv(12'd2047, 1'b0);
    conv(12'd0, 1'b1);
    conv(12'd4095, 1'b0);
    conv(12'd1365, 1'b1);
    conv(12'd2730, 1'b0);
    conv(12'd1, 1'b0);
    for (int i = 0; i < 6; i++) conv(N'($urandom), i[0]);
    repeat (5) @(negedge clk);
    conv(12'd777, 1'b0);
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule